// File: doc/BRIEF.md
# Forward-Distance Operand Delivery Unit

This unit takes the place of a named register file in a machine where every instruction says *when* its result is needed rather than *where* it goes. Each instruction that issues carries a 5-bit forward-distance field. The field tells how many instructions later in program order the consumer of its result sits. The unit keeps a circular store of per-consumer slots, indexed by the consumer's sequence index modulo the slot count. Each result is appended to the slot of its consumer.

Instructions issue in order, at most one per cycle. An issuing instruction reads its own slot in the same cycle and clears it. On the next cycle the unit presents the operands that arrived for that instruction, oldest first, together with how many there were. The consumer can then pick its behaviour from that count; for example, one operand on an add can mean an increment.

If a slot already holds its full number of operands, a further arrival is discarded and a sticky error flag is raised. A producer whose result has no consumer writes nothing.

Top module: `fdu_operand_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `rd_valid`, `rd_count`, `rd_ops` and `ovf_err` are all zero. Every slot starts empty.
- R2: A result issued at sequence index s with distance field value f (0 to 31) is delivered to the instruction with sequence index s+f+1. The distance therefore runs from 1 to 32, and the slot used is (s+f+1) mod 32.
- R3: For an instruction issued on the cycle ending at edge k, `rd_valid` is 1 after edge k. `rd_count` then equals the number of results that targeted it, up to 2. Operands appear in arrival order: the first in `rd_ops[15:0]` and the second in `rd_ops[31:16]`. Positions beyond `rd_count` read zero.
- R4: Issuing an instruction clears its slot. The instruction 32 positions later sees only results produced for it.
- R5: A result arriving at a slot that already holds 2 operands is discarded, and the 2 held operands are kept. `ovf_err` goes to 1 on the edge that handles the discarded result and stays 1 until reset.
- R6: A result issued with `iss_has_out` low is written to no slot.
- R7: With field value 31 (distance 32), the producer's own slot is first cleared for its own read and then holds the new result. The instruction 32 later receives exactly that one operand.
- R8: After a cycle with no issue, `rd_valid` is 0. Idle cycles leave every slot unchanged.
- R9: An instruction that no result targeted receives `rd_count` 0 and `rd_ops` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_seq | input | 8 | Sequence index of the issuing instruction, increasing by one per issue |
| iss_has_out | input | 1 | The issuing instruction produces a result that has a consumer |
| iss_dist | input | 5 | Forward-distance field; distance is this value plus one |
| iss_result | input | 16 | Result value of the issuing instruction |
| rd_valid | output | 1 | Operand outputs belong to the instruction issued in the previous cycle |
| rd_ops | output | 32 | Delivered operands, arrival order, first in the low half |
| rd_count | output | 2 | Number of operands delivered (0 to 2) |
| ovf_err | output | 1 | Sticky flag: an operand was dropped at a full slot |

## Verification
Every delivery appears one clock edge after the issue that asks for it. A result written on one edge can be read by any later issue, because a distance is never zero. The bench drives inputs on the falling edge and samples on the next falling edge, just after the single rising edge that registers the read. It compares the outputs with a per-slot queue model that it updates in the same order the requirements give: clear the reader's slot, then append the result. The overflow flag is due on that same edge, so the model's error bit is compared on every issue. Directed sequences cover the zero-operand, two-operand, no-consumer, wrap-distance and overflow cases. Several thousand random issues follow, with idle cycles mixed in.

// File: rtl/fdu_pkg.sv
package fdu_pkg;

  // Slot that holds operands for the instruction at sequence index seq.
  function automatic int unsigned fdu_slot_of(input int unsigned seq,
                                              input int unsigned slots);
    return seq % slots;
  endfunction

  // Slot of the consumer reached by distance field value fld (distance fld+1).
  function automatic int unsigned fdu_target(input int unsigned seq,
                                             input int unsigned fld,
                                             input int unsigned slots);
    return (seq + fld + 1) % slots;
  endfunction

endpackage

// File: rtl/fdu_route.sv
module fdu_route
  import fdu_pkg::*;
#(
  parameter int SEQ_W  = 8,
  parameter int DIST_W = 5,
  localparam int SLOTS = 1 << DIST_W
) (
  input  logic              iss_valid,
  input  logic              iss_has_out,
  input  logic [SEQ_W-1:0]  iss_seq,
  input  logic [DIST_W-1:0] iss_dist,
  output logic [DIST_W-1:0] rd_slot,
  output logic [SLOTS-1:0]  clr_vec,
  output logic [SLOTS-1:0]  wr_vec
);

  logic [DIST_W-1:0] wr_slot;

  assign rd_slot = DIST_W'(fdu_slot_of(int'(iss_seq), SLOTS));
  assign wr_slot = DIST_W'(fdu_target(int'(iss_seq), int'(iss_dist), SLOTS));

  for (genvar i = 0; i < SLOTS; i++) begin : g_dec
    assign clr_vec[i] = iss_valid && (rd_slot == DIST_W'(i));
    assign wr_vec[i]  = iss_valid && iss_has_out && (wr_slot == DIST_W'(i));
  end

endmodule

// File: rtl/fdu_slot.sv
module fdu_slot #(
  parameter int DATA_W  = 16,
  parameter int MAX_OPS = 2,
  localparam int CNT_W  = $clog2(MAX_OPS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [MAX_OPS*DATA_W-1:0] ops_q,
  output logic [CNT_W-1:0]          cnt_q,
  output logic                      ovf
);

  logic [CNT_W-1:0] base_cnt;
  logic             full;

  // A clear in the same cycle happens before the append.
  assign base_cnt = clr ? '0 : cnt_q;
  assign full     = (base_cnt == CNT_W'(MAX_OPS));
  assign ovf      = wr && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ops_q <= '0;
      cnt_q <= '0;
    end else begin
      if (clr) begin
        ops_q <= '0;
        cnt_q <= '0;
      end
      if (wr && !full) begin
        ops_q[int'(base_cnt)*DATA_W +: DATA_W] <= wr_data;
        cnt_q <= base_cnt + CNT_W'(1);
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_OPS));

  p_append_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && cnt_q < CNT_W'(MAX_OPS)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr) |=> (cnt_q == '0 && ops_q == '0));

  p_drop_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && cnt_q == CNT_W'(MAX_OPS)) |=> (ops_q == $past(ops_q) && cnt_q == CNT_W'(MAX_OPS)));

  p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !clr) |=> $stable(ops_q) && $stable(cnt_q));

endmodule

// File: rtl/fdu_operand_unit.sv
module fdu_operand_unit #(
  parameter int DATA_W  = 16,
  parameter int DIST_W  = 5,
  parameter int SEQ_W   = 8,
  parameter int MAX_OPS = 2,
  localparam int SLOTS  = 1 << DIST_W,
  localparam int CNT_W  = $clog2(MAX_OPS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_valid,
  input  logic [SEQ_W-1:0]          iss_seq,
  input  logic                      iss_has_out,
  input  logic [DIST_W-1:0]         iss_dist,
  input  logic [DATA_W-1:0]         iss_result,
  output logic                      rd_valid,
  output logic [MAX_OPS*DATA_W-1:0] rd_ops,
  output logic [CNT_W-1:0]          rd_count,
  output logic                      ovf_err
);

  logic [DIST_W-1:0]         rd_slot;
  logic [SLOTS-1:0]          clr_vec;
  logic [SLOTS-1:0]          wr_vec;
  logic [SLOTS-1:0]          ovf_vec;
  logic [MAX_OPS*DATA_W-1:0] slot_ops [SLOTS];
  logic [CNT_W-1:0]          slot_cnt [SLOTS];
  logic                      ovf_evt;

  fdu_route #(.SEQ_W(SEQ_W), .DIST_W(DIST_W)) route_i (
    .iss_valid   (iss_valid),
    .iss_has_out (iss_has_out),
    .iss_seq     (iss_seq),
    .iss_dist    (iss_dist),
    .rd_slot     (rd_slot),
    .clr_vec     (clr_vec),
    .wr_vec      (wr_vec)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    fdu_slot #(.DATA_W(DATA_W), .MAX_OPS(MAX_OPS)) slot_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_vec[i]),
      .wr      (wr_vec[i]),
      .wr_data (iss_result),
      .ops_q   (slot_ops[i]),
      .cnt_q   (slot_cnt[i]),
      .ovf     (ovf_vec[i])
    );
  end

  assign ovf_evt = |ovf_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_ops   <= '0;
      rd_count <= '0;
      ovf_err  <= 1'b0;
    end else begin
      rd_valid <= iss_valid;
      if (iss_valid) begin
        rd_ops   <= slot_ops[rd_slot];
        rd_count <= slot_cnt[rd_slot];
      end
      if (ovf_evt) ovf_err <= 1'b1;
    end
  end

  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  p_one_reader_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> $countones(clr_vec) == 1);

  p_no_out_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_has_out |-> wr_vec == '0);

  p_rd_follows_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> rd_valid);

  p_idle_no_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |=> !rd_valid);

  p_ovf_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_err);

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> $past(ovf_evt));

endmodule

// File: tb/fdu_operand_unit_tb.sv
module fdu_operand_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid;
  logic [7:0]  iss_seq;
  logic        iss_has_out;
  logic [4:0]  iss_dist;
  logic [15:0] iss_result;
  logic        rd_valid;
  logic [31:0] rd_ops;
  logic [1:0]  rd_count;
  logic        ovf_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int          mcnt [32];
  logic [15:0] mops [32][2];
  bit          merr;
  int          seq;

  always #5 clk = ~clk;

  fdu_operand_unit dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_seq(iss_seq),
    .iss_has_out(iss_has_out), .iss_dist(iss_dist), .iss_result(iss_result),
    .rd_valid(rd_valid), .rd_ops(rd_ops), .rd_count(rd_count), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Issue one instruction at the current falling edge; check its delivery one edge later.
  task automatic issue(input bit has, input int f, input logic [15:0] val, input string tag);
    int s = seq % 32;
    int ec = mcnt[s];
    logic [31:0] eo = {mops[s][1], mops[s][0]};
    mcnt[s] = 0; mops[s][0] = '0; mops[s][1] = '0;
    if (has) begin
      int t = (seq + f + 1) % 32;
      if (mcnt[t] < 2) begin mops[t][mcnt[t]] = val; mcnt[t]++; end
      else merr = 1;
    end
    iss_valid = 1; iss_seq = 8'(seq); iss_has_out = has;
    iss_dist = 5'(f); iss_result = val;
    @(negedge clk);
    iss_valid = 0; iss_has_out = 0;
    chk(rd_valid === 1'b1, {tag, " valid"}, longint'(rd_valid), 1);
    chk(rd_count === 2'(ec), {tag, " count"}, longint'(rd_count), ec);
    chk(rd_ops === eo, {tag, " ops"}, longint'(rd_ops), longint'(eo));
    chk(ovf_err === merr, {tag, " err"}, longint'(ovf_err), longint'(merr));
    seq++;
  endtask

  task automatic idle();
    iss_valid = 0;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R8 idle valid", longint'(rd_valid), 0);
    chk(ovf_err === merr, "R8 idle err", longint'(ovf_err), longint'(merr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; iss_valid = 0; iss_seq = 0; iss_has_out = 0; iss_dist = 0; iss_result = 0;
    merr = 0; seq = 0;
    for (int i = 0; i < 32; i++) begin mcnt[i] = 0; mops[i][0] = '0; mops[i][1] = '0; end
    repeat (3) @(negedge clk);
    chk(rd_valid === 0 && rd_count === 0, "R1 reset rd", longint'({rd_valid, rd_count}), 0);
    chk(rd_ops === '0 && ovf_err === 0, "R1 reset ops/err", longint'({ovf_err, rd_ops}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(rd_valid === 0 && ovf_err === 0, "R1 after release", longint'({rd_valid, ovf_err}), 0);

    // R2/R6/R9 directed
    issue(1, 2, 16'h1111, "R9 empty slot seq0");
    issue(0, 0, 16'hdead, "R9 empty slot seq1");
    issue(0, 0, 16'hbeef, "R6 no-out not written");
    issue(0, 0, 16'h0000, "R2 distance 3 delivered");
    // R3 two operands in arrival order
    issue(1, 1, 16'haaaa, "R3 producer a");
    issue(1, 0, 16'hbbbb, "R3 producer b");
    issue(0, 0, 16'h0000, "R3 two operands");
    // R7 wrap distance 32
    issue(1, 0, 16'hcccc, "R7 pre-write");
    issue(1, 31, 16'hdddd, "R7 own read");
    for (int i = 0; i < 31; i++) issue(0, 0, 16'h0, "R4 reuse clean");
    issue(0, 0, 16'h0, "R7 wrap delivery");
    idle(); idle();
    // R5 overflow
    issue(1, 2, 16'h0101, "R5 fill 1");
    issue(1, 1, 16'h0202, "R5 fill 2");
    issue(1, 0, 16'h0303, "R5 overflow");
    issue(0, 0, 16'h0, "R5 kept first two");
    chk(ovf_err === 1'b1, "R5 sticky set", longint'(ovf_err), 1);

    // Sweep every field value, then random traffic with idles
    for (int f = 0; f < 32; f++) issue(1, f, 16'(16'h4000 + f), "R2 field sweep");
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 9) == 0) idle();
      else issue($urandom_range(0, 9) < 7, int'($urandom_range(0, 31)),
                 16'($urandom), "R2 random");
    end
    chk(ovf_err === 1'b1, "R5 sticky end", longint'(ovf_err), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule